// File: doc/BRIEF.md
# Framed Command Transmitter with Reply Wait

The block sends one command frame at a time on an 8-bit ready/valid byte stream. A frame is assembled from a code byte, a payload count and up to 32 payload bytes that were written into a small internal buffer before the start pulse. On the wire the frame is wrapped in two fixed marker bytes and carries a one-byte XOR checksum, so every frame has exactly five bytes of overhead.

Once the closing marker has been accepted by the downstream sink, the block listens on a byte input for the far side's reply. A positive reply, a negative reply, or silence for longer than a programmable number of cycles ends the exchange. Each outcome is reported with a one-cycle pulse, and the block then accepts a new start. Resending a frame after a negative reply or a timeout is left to the logic that drives this block.

Top module: `frame_cmd_tx`

## Requirements
- R1: After reset, `tx_valid`, `busy`, `done_ok`, `done_nack` and `done_timeout` are all low.
- R2: A frame is sent as 0x7E, the code byte, the count byte, the payload bytes from buffer address 0 upward, the checksum byte and 0x7F, in that order. Its length is the count plus 5.
- R3: The checksum byte is the XOR of the code byte, the count byte and every payload byte. The two marker bytes are not included.
- R4: A requested count greater than 32 is treated as 32. The count byte then reads 32 and 32 payload bytes are sent.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change in the next cycle. No byte is skipped or repeated.
- R6: `start` has no effect while `busy` is high. `busy` is high from the cycle after an accepted start until the reply wait ends.
- R7: While waiting, a reply byte 0x06 with `rx_valid` high produces a one-cycle `done_ok`, and 0x15 produces a one-cycle `done_nack`. Any other reply byte is ignored. Only one done output is high at a time, and the block is idle when it is.
- R8: `done_timeout` pulses when no 0x06 or 0x15 has been seen in the `ack_limit`+1 cycles that follow the clock edge at which 0x7F was accepted. A reply in the last of those cycles still counts.
- R9: Buffer writes made while `busy` is high are ignored.
- R10: Reply bytes that arrive while a frame is still being sent produce no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Payload buffer write strobe |
| buf_addr | input | 5 | Payload buffer write address |
| buf_wdata | input | 8 | Payload buffer write byte |
| start | input | 1 | Frame start request |
| cmd_code | input | 8 | Code byte for the frame |
| pay_count | input | 6 | Requested payload byte count |
| ack_limit | input | 16 | Reply wait window, in cycles minus one |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Outgoing byte is valid |
| tx_ready | input | 1 | Sink accepts the byte |
| rx_data | input | 8 | Reply byte from the far side |
| rx_valid | input | 1 | Reply byte is valid |
| busy | output | 1 | Frame in flight or reply awaited |
| done_ok | output | 1 | Positive reply received (pulse) |
| done_nack | output | 1 | Negative reply received (pulse) |
| done_timeout | output | 1 | Reply window expired (pulse) |

## Verification
The assertions take `pay_count` as a stable value in the cycle of an accepted start. They also take `tx_ready` to be an arbitrary level that may toggle in any cycle, and reply bytes to be single-cycle strobes of any value. The stimulus draws `tx_ready` at random with about one cycle in four stalled. It holds `pay_count` and `cmd_code` steady across each start pulse. In the reply wait it places a garbage byte just before the real reply. Directed frames cover the empty payload, the full and over-range counts, a reply on the last cycle of the window, a zero-length window, and starts, buffer writes and replies injected while a frame is in flight.

// File: rtl/cmdtx_pkg.sv
package cmdtx_pkg;
  localparam logic [7:0] MARK_OPEN  = 8'h7E;
  localparam logic [7:0] MARK_CLOSE = 8'h7F;
  localparam logic [7:0] REPLY_POS  = 8'h06;
  localparam logic [7:0] REPLY_NEG  = 8'h15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_CODE, ST_CNT, ST_PAY, ST_SUM, ST_CLOSE, ST_WAIT
  } tx_state_t;

  // One step of the running frame checksum.
  function automatic logic [7:0] sum_step(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction
endpackage

// File: rtl/cmdtx_paybuf.sv
module cmdtx_paybuf #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cmdtx_replywait.sv
module cmdtx_replywait #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_wait,
  input  logic [TW-1:0] limit,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          hit_pos,
  output logic          hit_neg,
  output logic          hit_expire,
  output logic          done_ok,
  output logic          done_nack,
  output logic          done_timeout
);
  import cmdtx_pkg::*;

  logic [TW-1:0] timer;

  assign hit_pos    = in_wait && rx_valid && (rx_data == REPLY_POS);
  assign hit_neg    = in_wait && rx_valid && (rx_data == REPLY_NEG);
  assign hit_expire = in_wait && !hit_pos && !hit_neg && (timer == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer        <= '0;
      done_ok      <= 1'b0;
      done_nack    <= 1'b0;
      done_timeout <= 1'b0;
    end else begin
      done_ok      <= hit_pos;
      done_nack    <= hit_neg;
      done_timeout <= hit_expire;
      if (!in_wait)          timer <= '0;
      else if (timer != limit) timer <= timer + 1'b1;
    end
  end
endmodule

// File: rtl/cmdtx_framer.sv
module cmdtx_framer #(
  parameter int MAX_PAY = 32,
  localparam int AW = $clog2(MAX_PAY),
  localparam int CW = $clog2(MAX_PAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    code_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [7:0]    pay_byte,
  input  logic          tx_ready,
  input  logic          wait_end,
  output logic [AW-1:0] pay_idx,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          busy,
  output logic          in_wait,
  output logic          accept,
  output logic          close_fire
);
  import cmdtx_pkg::*;

  tx_state_t     state;
  logic [7:0]    code_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  logic [7:0]    sum;
  logic          fire;

  assign tx_valid   = (state != ST_IDLE) && (state != ST_WAIT);
  assign busy       = (state != ST_IDLE);
  assign in_wait    = (state == ST_WAIT);
  assign accept     = start && (state == ST_IDLE);
  assign fire       = tx_valid && tx_ready;
  assign close_fire = fire && (state == ST_CLOSE);
  assign pay_idx    = idx[AW-1:0];

  always_comb begin
    case (state)
      ST_OPEN:  tx_data = MARK_OPEN;
      ST_CODE:  tx_data = code_q;
      ST_CNT:   tx_data = 8'(cnt_q);
      ST_PAY:   tx_data = pay_byte;
      ST_SUM:   tx_data = sum;
      ST_CLOSE: tx_data = MARK_CLOSE;
      default:  tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      code_q <= '0;
      cnt_q  <= '0;
      idx    <= '0;
      sum    <= '0;
    end else if (accept) begin
      state  <= ST_OPEN;
      code_q <= code_in;
      cnt_q  <= cnt_in;
      idx    <= '0;
      sum    <= '0;
    end else if (in_wait) begin
      if (wait_end) state <= ST_IDLE;
    end else if (fire) begin
      case (state)
        ST_OPEN: state <= ST_CODE;
        ST_CODE: begin
          sum   <= sum_step(sum, code_q);
          state <= ST_CNT;
        end
        ST_CNT: begin
          sum   <= sum_step(sum, 8'(cnt_q));
          state <= (cnt_q == '0) ? ST_SUM : ST_PAY;
        end
        ST_PAY: begin
          sum <= sum_step(sum, pay_byte);
          if (idx == cnt_q - 1'b1) state <= ST_SUM;
          else                     idx   <= idx + 1'b1;
        end
        ST_SUM:   state <= ST_CLOSE;
        ST_CLOSE: state <= ST_WAIT;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_cmd_tx.sv
module frame_cmd_tx #(
  parameter int MAX_PAY = 32,
  parameter int TW      = 16,
  localparam int AW = $clog2(MAX_PAY),
  localparam int CW = $clog2(MAX_PAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  input  logic          start,
  input  logic [7:0]    cmd_code,
  input  logic [CW-1:0] pay_count,
  input  logic [TW-1:0] ack_limit,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          busy,
  output logic          done_ok,
  output logic          done_nack,
  output logic          done_timeout
);
  logic [CW-1:0] cnt_eff;
  logic [AW-1:0] pay_idx;
  logic [7:0]    pay_byte;
  logic          in_wait, accept, close_fire;
  logic          hit_pos, hit_neg, hit_expire;

  assign cnt_eff = (pay_count > CW'(MAX_PAY)) ? CW'(MAX_PAY) : pay_count;

  cmdtx_paybuf #(.DEPTH(MAX_PAY)) u_buf (
    .clk(clk), .we(buf_we && !busy), .waddr(buf_addr), .wdata(buf_wdata),
    .raddr(pay_idx), .rdata(pay_byte)
  );

  cmdtx_framer #(.MAX_PAY(MAX_PAY)) u_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .code_in(cmd_code),
    .cnt_in(cnt_eff), .pay_byte(pay_byte), .tx_ready(tx_ready),
    .wait_end(hit_pos || hit_neg || hit_expire), .pay_idx(pay_idx),
    .tx_data(tx_data), .tx_valid(tx_valid), .busy(busy), .in_wait(in_wait),
    .accept(accept), .close_fire(close_fire)
  );

  cmdtx_replywait #(.TW(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .in_wait(in_wait), .limit(ack_limit),
    .rx_valid(rx_valid), .rx_data(rx_data), .hit_pos(hit_pos),
    .hit_neg(hit_neg), .hit_expire(hit_expire), .done_ok(done_ok),
    .done_nack(done_nack), .done_timeout(done_timeout)
  );
endmodule

// File: rtl/cmdtx_checker.sv
module cmdtx_checker #(
  parameter int MAX_PAY = 32,
  localparam int CW = $clog2(MAX_PAY + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] pay_count,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          busy,
  input logic          in_wait,
  input logic          accept,
  input logic          close_fire,
  input logic          done_ok,
  input logic          done_nack,
  input logic          done_timeout
);
  logic [7:0] seen;
  logic [7:0] want;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      want <= '0;
    end else if (accept) begin
      seen <= '0;
      want <= (int'(pay_count) > MAX_PAY) ? 8'(MAX_PAY) : 8'(pay_count);
    end else if (tx_valid && tx_ready) begin
      seen <= seen + 1'b1;
    end
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R5
  AST_OPEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tx_valid && tx_data == 8'h7E); // R2
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    close_fire |-> seen == want + 8'd4); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start) && !$past(busy)); // R6
  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, done_nack, done_timeout})); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_nack || done_timeout) |-> !busy); // R8
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !tx_valid); // R10
endmodule

bind frame_cmd_tx cmdtx_checker #(.MAX_PAY(MAX_PAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pay_count(pay_count),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy),
  .in_wait(in_wait), .accept(accept), .close_fire(close_fire),
  .done_ok(done_ok), .done_nack(done_nack), .done_timeout(done_timeout)
);

// File: tb/sim_frame_cmd_tx.sv
module sim_frame_cmd_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_we = 1'b0;
  logic [4:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic       start = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [5:0] pay_count = '0;
  logic [15:0] ack_limit = 16'd20;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       busy, done_ok, done_nack, done_timeout;

  int checks = 0;
  int errors = 0;
  logic [7:0] pay [32];

  always #4 clk = ~clk;

  frame_cmd_tx u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xsum(input logic [7:0] c, input int n);
    logic [7:0] s = c ^ 8'(n);
    for (int i = 0; i < n; i++) s = s ^ pay[i];
    return s;
  endfunction

  task automatic load_all();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      pay[i] = 8'($urandom);
      buf_we = 1'b1; buf_addr = 5'(i); buf_wdata = pay[i];
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  // mode 0: positive reply, 1: negative reply, 2: no reply
  task automatic run_frame(input logic [7:0] c, input int n_in, input int mode,
                           input int reply_at, input bit poke);
    int n = (n_in > 32) ? 32 : n_in;
    int len = n + 5;
    logic [7:0] exp [40];
    int got = 0, it = 0, k = 0;
    bit early = 0, hold = 0, bad = 0;
    logic [7:0] held = '0;
    exp[0] = 8'h7E; exp[1] = c; exp[2] = 8'(n);
    for (int i = 0; i < n; i++) exp[3 + i] = pay[i];
    exp[n + 3] = xsum(c, n); exp[n + 4] = 8'h7F;
    @(negedge clk);
    cmd_code = c; pay_count = 6'(n_in); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6", busy, 1);
    while (got < len && it < 2000) begin
      if (it > 0) @(negedge clk);
      it++;
      start = 1'b0; buf_we = 1'b0; rx_valid = 1'b0;
      if (done_ok || done_nack || done_timeout) early = 1;
      if (hold) begin
        chk(tx_valid && tx_data == held, "R5", tx_data, held);
      end
      if (poke && it == 3) begin
        start = 1'b1; cmd_code = ~c;
        buf_we = 1'b1; buf_addr = 5'd0; buf_wdata = ~pay[0];
        rx_valid = 1'b1; rx_data = 8'h06;
      end
      tx_ready = ($urandom % 4) != 0;
      hold = tx_valid && !tx_ready;
      held = tx_data;
      if (tx_valid && tx_ready) begin
        if (tx_data != exp[got]) begin
          bad = 1;
          chk(0, (got == len - 2) ? "R3" : "R2", tx_data, exp[got]);
        end
        got++;
      end
    end
    chk(!bad && got == len, "R2", got, len);
    if (n > 0 || n_in > 32) chk(exp[2] == 8'(n), "R4", exp[2], n);
    chk(!early, "R10", early, 0);
    while (k < 200) begin
      @(negedge clk);
      k++;
      start = 1'b0; buf_we = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
      if (done_ok || done_nack || done_timeout) break;
      if (mode < 2 && k == reply_at - 1) begin
        rx_valid = 1'b1; rx_data = 8'h55;
      end
      if (mode < 2 && k == reply_at) begin
        rx_valid = 1'b1; rx_data = (mode == 0) ? 8'h06 : 8'h15;
      end
    end
    if (mode == 0) chk(done_ok && !done_nack && k == reply_at + 1, "R7", k, reply_at + 1);
    if (mode == 1) chk(done_nack && !done_ok && k == reply_at + 1, "R7", k, reply_at + 1);
    if (mode == 2) chk(done_timeout && k == int'(ack_limit) + 2, "R8", k, int'(ack_limit) + 2);
    chk(!busy && !tx_valid, "R7", busy, 0);
    @(negedge clk);
    chk(!done_ok && !done_nack && !done_timeout, "R7", done_ok, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!tx_valid && !busy && !done_ok && !done_nack && !done_timeout, "R1", busy, 0);
    rst_n = 1'b1;
    load_all();
    ack_limit = 16'd20;
    run_frame(8'hA5, 0, 0, 1, 0);            // R2 empty payload
    run_frame(8'h3C, 32, 1, 21, 0);          // R8 reply in the last window cycle
    run_frame(8'h11, 40, 0, 4, 0);           // R4 clamp
    run_frame(8'h5A, 6, 0, 3, 1);            // R6 R9 R10 pokes in flight
    run_frame(8'h5A, 6, 0, 2, 0);            // R9 buffer unchanged
    ack_limit = 16'd5;
    run_frame(8'hC3, 3, 2, 0, 0);            // R8 timeout
    ack_limit = 16'd0;
    run_frame(8'h0F, 1, 2, 0, 0);            // R8 zero-length window
    for (int f = 0; f < 10; f++) begin
      ack_limit = 16'(4 + $urandom % 30);
      load_all();
      run_frame(8'($urandom), int'($urandom % 41), int'($urandom % 3),
                1 + int'($urandom % (int'(ack_limit) + 1)), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule